// File: doc/BRIEF.md
# Per-Address Breakpoint Shadow Memory

The block holds breakpoints as a shadow store with one byte for every emulated address. It does not use a bank of address comparators. Each bit of a byte stands for one kind of breakpoint. On every target bus cycle the block reads the byte at the cycle's address. It keeps only the bits that the cycle type and the running task allow. If any bit is left, it raises a break request that carries the mask of matched kinds. Because every address has its own byte, the number of breakpoints has no fixed limit.

A host sets or clears breakpoint bits with a fill command that gives a first and a last address, a bit mask and a set/clear flag. A single address is a fill whose first and last addresses are equal. The sequencer writes one address per clock. Target lookups always win the shared store, so a fill stalls for every clock that carries a target cycle. The break request stays latched until the host clears it. Each kind can be locked to one task, for example so that it fires only while the foreground program runs.

Top module: `bp_shadow_unit`

## Requirements
- R1: Every address owns an 8-bit breakpoint byte with these fixed bit positions: bit 0 program, bit 1 high-level (marks source-line starts), bit 2 spot, bit 3 data read, bit 4 data write, bits 5, 6 and 7 general-purpose A, B and C. A cycle can match several kinds at once, and `brk_kinds` then reports all of them.
- R2: A target cycle is sampled on one clock edge. If it matches, `brk_req` and `brk_kinds` change on the second edge after it.
- R3: The program and high-level bits match only on opcode-fetch cycles (`tgt_type` = 0).
- R4: The data-read bit matches only on read cycles (`tgt_type` = 1). The data-write bit matches only on write cycles (`tgt_type` = 2).
- R5: The spot bit and the three general-purpose bits match on every cycle type, including type 3 (other).
- R6: When `lock_en[k]` is 1, kind k matches only if `tgt_task` equals `lock_task[k*TASK_W +: TASK_W]`. When `lock_en[k]` is 0, kind k matches for any task.
- R7: When the block is idle, `cmd_go` starts a fill and `busy` is 1 from the next edge. The fill writes one address per unstalled clock, from `cmd_lo` up to `cmd_hi`. `busy` drops on the edge that writes `cmd_hi`. A `cmd_go` given while `busy` is 1 is ignored.
- R8: A fill changes only the bits selected by `cmd_mask`. It sets them when `cmd_set` is 1 and clears them when it is 0. The other bits of each byte keep their values.
- R9: A match latches `brk_req` = 1 and the matched kinds. These hold until a `brk_clr` edge. Matches that occur while `brk_req` is 1, or on the clear edge, are discarded.
- R10: A clock that carries a target cycle (`tgt_valid` = 1) performs no fill write. The fill therefore lasts one extra clock for each such cycle.
- R11: After reset, `busy`, `brk_req` and `brk_kinds` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | A target bus cycle is present |
| tgt_addr | input | ADDR_W | Target cycle address |
| tgt_type | input | 2 | 0 fetch, 1 read, 2 write, 3 other |
| tgt_task | input | TASK_W | Task running on the target |
| lock_en | input | 8 | Per-kind task lock enable |
| lock_task | input | 8*TASK_W | Per-kind locked task number |
| cmd_go | input | 1 | Start a fill command |
| cmd_lo | input | ADDR_W | First fill address |
| cmd_hi | input | ADDR_W | Last fill address |
| cmd_mask | input | 8 | Bits the fill touches |
| cmd_set | input | 1 | 1 sets the masked bits, 0 clears them |
| busy | output | 1 | A fill is in progress |
| brk_clr | input | 1 | Clear the pending break |
| brk_req | output | 1 | Break request pending |
| brk_kinds | output | 8 | Kinds matched by the latched break |

## Verification
The assertions assume the following about the inputs:
- `tgt_type` and the cycle-validity input are driven and known on every clock after reset.
- The host does not raise `brk_clr` and expect a new match to be captured on the same edge.
- A fill's first address is not above its last address, so that a fill does not wrap around.

The stimulus respects these limits:
- It drives every input away from the active clock edge.
- It keeps `cmd_lo` ≤ `cmd_hi`.
- It clears the whole store before the first target lookup, so no lookup ever reads a byte that was never written.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int NKIND = 8;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_OTHER = 2'd3
  } cyc_e;

  // bit positions inside one shadow byte
  localparam int K_PROG  = 0;
  localparam int K_HLL   = 1;
  localparam int K_SPOT  = 2;
  localparam int K_DRD   = 3;
  localparam int K_DWR   = 4;
  localparam int K_GPA   = 5;
  localparam int K_GPB   = 6;
  localparam int K_GPC   = 7;
endpackage

// File: rtl/bpm_plane.sv
// One bit plane of the shadow store: simple dual-port, registered read.
module bpm_plane #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/bpm_qualify.sv
// Builds the mask of kinds that this cycle type and task allow.
module bpm_qualify
  import bpm_pkg::*;
#(
  parameter int TASK_W = 2
) (
  input  logic [1:0]              cyc_type,
  input  logic [TASK_W-1:0]       cur_task,
  input  logic [NKIND-1:0]        lock_en,
  input  logic [NKIND*TASK_W-1:0] lock_task,
  output logic [NKIND-1:0]        allow
);
  logic [NKIND-1:0] type_ok;
  logic [NKIND-1:0] task_ok;
  cyc_e ct;

  always_comb begin
    ct = cyc_e'(cyc_type);
    type_ok         = '1;
    type_ok[K_PROG] = (ct == CYC_FETCH);
    type_ok[K_HLL]  = (ct == CYC_FETCH);
    type_ok[K_DRD]  = (ct == CYC_READ);
    type_ok[K_DWR]  = (ct == CYC_WRITE);
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_task
    assign task_ok[k] = !lock_en[k] ||
                        (lock_task[k*TASK_W +: TASK_W] == cur_task);
  end

  assign allow = type_ok & task_ok;
endmodule

// File: rtl/bpm_fill_seq.sv
// Walks an address range, one masked write per unstalled clock.
module bpm_fill_seq
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [NKIND-1:0]  mask,
  input  logic              set,
  input  logic              stall,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [NKIND-1:0]  wmask,
  output logic              wset
);
  logic [ADDR_W-1:0] last_q;

  assign we = busy && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      waddr  <= '0;
      last_q <= '0;
      wmask  <= '0;
      wset   <= 1'b0;
    end else if (busy) begin
      if (!stall) begin
        if (waddr == last_q) busy <= 1'b0;
        else                 waddr <= waddr + 1'b1;
      end
    end else if (go) begin
      busy   <= 1'b1;
      waddr  <= lo;
      last_q <= hi;
      wmask  <= mask;
      wset   <= set;
    end
  end
endmodule

// File: rtl/bp_shadow_unit.sv
module bp_shadow_unit
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TASK_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tgt_valid,
  input  logic [ADDR_W-1:0]       tgt_addr,
  input  logic [1:0]              tgt_type,
  input  logic [TASK_W-1:0]       tgt_task,
  input  logic [NKIND-1:0]        lock_en,
  input  logic [NKIND*TASK_W-1:0] lock_task,
  input  logic                    cmd_go,
  input  logic [ADDR_W-1:0]       cmd_lo,
  input  logic [ADDR_W-1:0]       cmd_hi,
  input  logic [NKIND-1:0]        cmd_mask,
  input  logic                    cmd_set,
  output logic                    busy,
  input  logic                    brk_clr,
  output logic                    brk_req,
  output logic [NKIND-1:0]        brk_kinds
);
  logic              fill_we;
  logic [ADDR_W-1:0] fill_addr;
  logic [NKIND-1:0]  fill_mask;
  logic              fill_set;
  logic [NKIND-1:0]  allow;
  logic [NKIND-1:0]  allow_q;
  logic              look_q;
  logic [NKIND-1:0]  shadow_q;
  logic [NKIND-1:0]  hit;

  bpm_fill_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .go(cmd_go), .lo(cmd_lo), .hi(cmd_hi),
    .mask(cmd_mask), .set(cmd_set), .stall(tgt_valid), .busy(busy),
    .we(fill_we), .waddr(fill_addr), .wmask(fill_mask), .wset(fill_set)
  );

  for (genvar k = 0; k < NKIND; k++) begin : g_plane
    bpm_plane #(.ADDR_W(ADDR_W)) u_plane (
      .clk(clk), .we(fill_we && fill_mask[k]), .waddr(fill_addr),
      .wbit(fill_set), .raddr(tgt_addr), .rbit(shadow_q[k])
    );
  end

  bpm_qualify #(.TASK_W(TASK_W)) u_qual (
    .cyc_type(tgt_type), .cur_task(tgt_task), .lock_en(lock_en),
    .lock_task(lock_task), .allow(allow)
  );

  // lookup stage, aligned with the registered store read
  always_ff @(posedge clk) begin
    if (rst) begin
      look_q  <= 1'b0;
      allow_q <= '0;
    end else begin
      look_q  <= tgt_valid;
      allow_q <= allow;
    end
  end

  assign hit = look_q ? (shadow_q & allow_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req   <= 1'b0;
      brk_kinds <= '0;
    end else if (brk_clr) begin
      brk_req   <= 1'b0;
      brk_kinds <= '0;
    end else if (!brk_req && (hit != '0)) begin
      brk_req   <= 1'b1;
      brk_kinds <= hit;
    end
  end
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker (
  input logic       clk,
  input logic       rst,
  input logic       tgt_valid,
  input logic [1:0] tgt_type,
  input logic       cmd_go,
  input logic       busy,
  input logic       brk_clr,
  input logic       brk_req,
  input logic [7:0] brk_kinds
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    brk_req && !brk_clr |=> brk_req && $stable(brk_kinds));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    brk_clr |=> !brk_req && brk_kinds == 8'h00);

  p_pending_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> brk_kinds != 8'h00);

  p_start_r7: assert property (@(posedge clk) disable iff (rst)
    !busy && cmd_go |=> busy);

  p_stall_keeps_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy && tgt_valid |=> busy);

  p_fetch_only_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_req) && (brk_kinds[0] || brk_kinds[1]) |->
      $past(tgt_valid, 2) && $past(tgt_type, 2) == 2'd0);

  p_read_only_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_req) && brk_kinds[3] |->
      $past(tgt_valid, 2) && $past(tgt_type, 2) == 2'd1);

  p_write_only_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_req) && brk_kinds[4] |->
      $past(tgt_valid, 2) && $past(tgt_type, 2) == 2'd2);
endmodule

bind bp_shadow_unit bpm_checker u_chk (
  .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_type(tgt_type),
  .cmd_go(cmd_go), .busy(busy), .brk_clr(brk_clr), .brk_req(brk_req),
  .brk_kinds(brk_kinds)
);

// File: tb/bp_shadow_unit_test.sv
module bp_shadow_unit_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        tgt_valid = 0;
  logic [7:0]  tgt_addr = 0;
  logic [1:0]  tgt_type = 0;
  logic [1:0]  tgt_task = 0;
  logic [7:0]  lock_en = 0;
  logic [15:0] lock_task = 0;
  logic        cmd_go = 0;
  logic [7:0]  cmd_lo = 0, cmd_hi = 0, cmd_mask = 0;
  logic        cmd_set = 0;
  logic        busy, brk_clr = 0, brk_req;
  logic [7:0]  brk_kinds;

  int errors = 0, checks = 0, cyc = 0;

  bp_shadow_unit uut (
    .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_addr(tgt_addr),
    .tgt_type(tgt_type), .tgt_task(tgt_task), .lock_en(lock_en),
    .lock_task(lock_task), .cmd_go(cmd_go), .cmd_lo(cmd_lo),
    .cmd_hi(cmd_hi), .cmd_mask(cmd_mask), .cmd_set(cmd_set), .busy(busy),
    .brk_clr(brk_clr), .brk_req(brk_req), .brk_kinds(brk_kinds)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  bit [7:0] m_mem [256];
  bit       m_busy, m_set, m_pend, m_sv;
  bit [7:0] m_cur, m_end, m_mask, m_kinds, m_sb, m_sq;

  function automatic bit [7:0] allowed(bit [1:0] ty, bit [1:0] tk,
                                       bit [7:0] le, bit [15:0] lt);
    bit [7:0] r;
    for (int k = 0; k < 8; k++) begin
      bit ok;
      case (k)
        0, 1:    ok = (ty == 0);
        3:       ok = (ty == 1);
        4:       ok = (ty == 2);
        default: ok = 1;
      endcase
      if (le[k] && lt[k*2 +: 2] != tk) ok = 0;
      r[k] = ok;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_pend = 0; m_kinds = 0; m_sv = 0; m_sq = 0;
    end else begin
      bit [7:0] hit;
      hit = m_sv ? (m_sb & m_sq) : 8'h00;
      if (brk_clr) begin m_pend = 0; m_kinds = 0; end
      else if (!m_pend && hit != 0) begin m_pend = 1; m_kinds = hit; end
      m_sv = tgt_valid;
      m_sb = m_mem[tgt_addr];
      m_sq = allowed(tgt_type, tgt_task, lock_en, lock_task);
      if (m_busy) begin
        if (!tgt_valid) begin
          m_mem[m_cur] = m_set ? (m_mem[m_cur] | m_mask)
                               : (m_mem[m_cur] & ~m_mask);
          if (m_cur == m_end) m_busy = 0;
          else m_cur++;
        end
      end else if (cmd_go) begin
        m_busy = 1; m_cur = cmd_lo; m_end = cmd_hi;
        m_mask = cmd_mask; m_set = cmd_set;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(busy === m_busy, "R7 busy vs model", busy, m_busy);
      chk(brk_req === m_pend, "R9 brk_req vs model", brk_req, m_pend);
      chk(brk_kinds === m_kinds, "R9 brk_kinds vs model", brk_kinds, m_kinds);
    end
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic fill(bit [7:0] lo, bit [7:0] hi, bit [7:0] msk, bit s);
    @(negedge clk);
    cmd_go = 1; cmd_lo = lo; cmd_hi = hi; cmd_mask = msk; cmd_set = s;
    @(negedge clk);
    cmd_go = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic look(bit [7:0] a, bit [1:0] ty, bit [1:0] tk);
    @(negedge clk);
    tgt_valid = 1; tgt_addr = a; tgt_type = ty; tgt_task = tk;
    @(negedge clk);
    tgt_valid = 0;
    @(negedge clk);
  endtask

  task automatic clear_brk();
    @(negedge clk); brk_clr = 1;
    @(negedge clk); brk_clr = 0;
  endtask

  initial begin
    int bcnt;
    repeat (3) @(negedge clk);
    chk(busy === 0 && brk_req === 0 && brk_kinds === 0, "R11 reset state",
        {busy, brk_req, brk_kinds}, 0);
    rst = 0;

    // R10: clear whole store with 5 stalls at an already cleared address
    @(negedge clk);
    cmd_go = 1; cmd_lo = 0; cmd_hi = 8'hFF; cmd_mask = 8'hFF; cmd_set = 0;
    @(negedge clk);
    cmd_go = 0; bcnt = 1;
    repeat (10) begin @(negedge clk); bcnt++; end
    tgt_valid = 1; tgt_addr = 0; tgt_type = 3;
    repeat (5) begin @(negedge clk); bcnt++; end
    tgt_valid = 0;
    while (busy) begin @(negedge clk); if (busy) bcnt++; end
    chk(bcnt == 261, "R10 fill stretched by stalls", bcnt, 261);

    // R3 and R1: program bit
    fill(8'h10, 8'h10, 8'h01, 1);
    look(8'h10, 1, 0);
    chk(brk_req === 0, "R3 program bit ignored on read", brk_req, 0);
    look(8'h10, 0, 0);
    chk(brk_kinds === 8'h01, "R3 program bit on fetch", brk_kinds, 1);
    clear_brk();
    chk(brk_req === 0, "R9 clear drops request", brk_req, 0);

    // R4
    fill(8'h20, 8'h20, 8'h08, 1);
    fill(8'h21, 8'h21, 8'h10, 1);
    look(8'h20, 2, 0);
    chk(brk_req === 0, "R4 read bit ignored on write", brk_req, 0);
    look(8'h20, 1, 0);
    chk(brk_kinds === 8'h08, "R4 read bit on read", brk_kinds, 8'h08);
    clear_brk();
    look(8'h21, 2, 0);
    chk(brk_kinds === 8'h10, "R4 write bit on write", brk_kinds, 8'h10);
    clear_brk();

    // R7: range fill length, R5 boundary
    @(negedge clk);
    cmd_go = 1; cmd_lo = 8'h30; cmd_hi = 8'h37; cmd_mask = 8'h04; cmd_set = 1;
    @(negedge clk);
    cmd_go = 0; bcnt = 1;
    while (busy) begin @(negedge clk); if (busy) bcnt++; end
    chk(bcnt == 8, "R7 one address per clock", bcnt, 8);
    look(8'h37, 3, 0);
    chk(brk_kinds === 8'h04, "R5 spot on other cycle at range end",
        brk_kinds, 8'h04);
    clear_brk();
    look(8'h38, 3, 0);
    chk(brk_req === 0, "R7 address past range untouched", brk_req, 0);

    // R8
    fill(8'h30, 8'h30, 8'h20, 1);
    fill(8'h30, 8'h30, 8'h04, 0);
    look(8'h30, 0, 0);
    chk(brk_kinds === 8'h20, "R8 masked clear keeps other bits",
        brk_kinds, 8'h20);
    clear_brk();

    // R6
    fill(8'h50, 8'h50, 8'h40, 1);
    lock_en = 8'h40; lock_task = 16'h1000;   // kind 6 locked to task 1
    look(8'h50, 1, 0);
    chk(brk_req === 0, "R6 locked kind ignored in other task", brk_req, 0);
    look(8'h50, 1, 1);
    chk(brk_kinds === 8'h40, "R6 locked kind in its task", brk_kinds, 8'h40);
    clear_brk();
    lock_en = 0;

    // R1 all bits on fetch, R2 latency
    fill(8'h60, 8'h60, 8'hFF, 1);
    @(negedge clk);
    tgt_valid = 1; tgt_addr = 8'h60; tgt_type = 0;
    @(negedge clk);
    tgt_valid = 0;
    chk(brk_req === 0, "R2 no request after one edge", brk_req, 0);
    @(negedge clk);
    chk(brk_req === 1, "R2 request after two edges", brk_req, 1);
    chk(brk_kinds === 8'hE7, "R1 all fetch-capable kinds", brk_kinds, 8'hE7);

    // R9: pending ignores new match
    look(8'h21, 2, 0);
    chk(brk_kinds === 8'hE7, "R9 new match ignored while pending",
        brk_kinds, 8'hE7);
    clear_brk();
    look(8'h21, 2, 0);
    chk(brk_kinds === 8'h10, "R9 capture after clear", brk_kinds, 8'h10);
    clear_brk();

    // R7: go ignored while busy
    @(negedge clk);
    cmd_go = 1; cmd_lo = 8'h70; cmd_hi = 8'h7F; cmd_mask = 8'h80; cmd_set = 1;
    @(negedge clk);
    cmd_lo = 8'h80; cmd_hi = 8'h80;
    @(negedge clk);
    cmd_go = 0;
    while (busy) @(negedge clk);
    look(8'h80, 3, 0);
    chk(brk_req === 0, "R7 second go ignored", brk_req, 0);
    look(8'h7F, 3, 0);
    chk(brk_kinds === 8'h80, "R7 first fill done", brk_kinds, 8'h80);
    clear_brk();

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule